// File: doc/BRIEF.md
# Load-Use Stall and Branch Flush Controller

This block sits beside the decode stage of a five-stage in-order pipeline and drives its pipeline control. It compares the destination of a load now in the execute stage with the two source registers of the instruction in decode. When the decode instruction needs a loaded value that is not yet available, the block freezes the program counter and the fetch/decode register for one cycle. In the same cycle it zeroes the control bits loaded into the decode/execute register, so that one bubble moves into execute. After that single cycle the loaded value can be forwarded from the writeback side, and the pipeline runs on.

Branches are predicted not taken and are resolved by a comparator in decode. When that comparator reports a wrong prediction, the block raises a flush for the fetch/decode register. At the next edge that register loads an all-zero no-op in place of the one wrongly fetched instruction. If a stall and a flush are both requested in the same cycle, the stall wins. The branch is still in decode on the next cycle and is judged again then.

The sequencer has three states. RUN is normal flow. HOLD is the one cycle after a stall, during which the load has moved on and no new load-use match is honoured. SQUASH is the one cycle after a flush, when decode holds the inserted no-op and no mispredict is honoured. The transitions are as follows. RUN, HOLD and SQUASH go to HOLD on an honoured load-use match. They go to SQUASH on an honoured mispredict that no stall overrides. They go to RUN otherwise. HOLD cannot take the stall transition, and SQUASH cannot take the flush transition.

Top module: `hz_stall_flush_ctrl`

## Requirements
- R1: After reset the sequencer is in RUN. With all inputs low, `pc_write_en`=1, `ifid_write_en`=1, `idex_ctrl_zero`=0 and `ifid_flush`=0.
- R2: In RUN or SQUASH, a load-use match forces, in the same cycle, `pc_write_en`=0, `ifid_write_en`=0 and `idex_ctrl_zero`=1. A match means `idex_mem_read`=1, `idex_rt` non-zero, and `idex_rt` equal to `ifid_rs` or to `ifid_rt`.
- R3: When `idex_mem_read`=0, or when `idex_rt` equals neither decode source, no stall is raised.
- R4: A load whose `idex_rt` is register 0 never raises a stall, even when a decode source is also 0.
- R5: A stall lasts exactly one cycle. In the cycle after a stall (HOLD), a load-use match is ignored and the write enables are 1.
- R6: In RUN or HOLD, `id_br_mispredict`=1 with no stall raised gives `ifid_flush`=1, with both write enables 1 and `idex_ctrl_zero`=0.
- R7: A flush lasts one cycle. In the cycle after a flush (SQUASH), `id_br_mispredict` is ignored and `ifid_flush`=0.
- R8: When a stall and a mispredict coincide, the stall is raised and `ifid_flush`=0. If the mispredict is still present on the next cycle, the flush is raised then.
- R9: `pc_write_en` always equals `ifid_write_en`, `idex_ctrl_zero` is their inverse, and `ifid_flush` is never high together with `idex_ctrl_zero`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| idex_mem_read | input | 1 | Instruction in execute is a load |
| idex_rt | input | 5 | Destination register of the load in execute |
| ifid_rs | input | 5 | First source register of the decode instruction |
| ifid_rt | input | 5 | Second source register of the decode instruction |
| id_br_mispredict | input | 1 | Decode comparator found a taken branch (predicted not taken) |
| pc_write_en | output | 1 | Program counter may update |
| ifid_write_en | output | 1 | Fetch/decode register may update |
| idex_ctrl_zero | output | 1 | Load zeros into decode/execute control bits (bubble) |
| ifid_flush | output | 1 | Fetch/decode register loads the all-zero no-op at the next edge |

## Verification
The assertions assume that every input is known and settled before the rising edge, and that the mispredict flag comes only from the decode comparator. The checker infers HOLD and SQUASH from its own record of the previous cycle's outputs, so it takes for granted that nothing but the sequencer changes state. The stimulus changes all inputs only at the falling edge and draws register numbers from a small range, so matches, register-0 loads and coincident stall/flush requests occur often. Directed cycles cover back-to-back stall and flush sequences.

// File: rtl/hz_pkg.sv
package hz_pkg;
    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_HOLD   = 2'd1,
        ST_SQUASH = 2'd2
    } hz_state_e;
endpackage

// File: rtl/hz_loaduse_detect.sv
module hz_loaduse_detect #(
    parameter int REG_W   = 5,
    parameter int NUM_SRC = 2
) (
    input  logic                            ld_valid,
    input  logic [REG_W-1:0]                ld_dest,
    input  logic [NUM_SRC-1:0][REG_W-1:0]   src_regs,
    output logic                            match
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic [NUM_SRC-1:0] src_hit;

    genvar g;
    generate
        for (g = 0; g < NUM_SRC; g++) begin : g_cmp
            assign src_hit[g] = (src_regs[g] == ld_dest);
        end
    endgenerate

    // register 0 is hard-wired; a load into it never creates a dependence
    assign match = ld_valid && (ld_dest != ZERO_REG) && (|src_hit);
endmodule

// File: rtl/hz_seq.sv
module hz_seq
    import hz_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic lu_match,
    input  logic br_mis,
    output logic pc_we,
    output logic ifid_we,
    output logic ctrl_zero,
    output logic flush
);
    hz_state_e state_q, state_d;
    logic      stall_ok;
    logic      flush_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        stall_ok  = 1'b0;
        flush_ok  = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                stall_ok = lu_match;
                flush_ok = br_mis;
            end
            ST_HOLD: begin
                stall_ok = 1'b0;
                flush_ok = br_mis;
            end
            ST_SQUASH: begin
                stall_ok = lu_match;
                flush_ok = 1'b0;
            end
            default: begin
                stall_ok = 1'b0;
                flush_ok = 1'b0;
            end
        endcase

        pc_we     = 1'b1;
        ifid_we   = 1'b1;
        ctrl_zero = 1'b0;
        flush     = 1'b0;
        state_d   = ST_RUN;
        if (stall_ok) begin
            pc_we     = 1'b0;
            ifid_we   = 1'b0;
            ctrl_zero = 1'b1;
            state_d   = ST_HOLD;
        end else if (flush_ok) begin
            flush     = 1'b1;
            state_d   = ST_SQUASH;
        end
    end
endmodule

// File: rtl/hz_stall_flush_ctrl.sv
module hz_stall_flush_ctrl #(
    parameter int REG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idex_mem_read,
    input  logic [REG_W-1:0] idex_rt,
    input  logic [REG_W-1:0] ifid_rs,
    input  logic [REG_W-1:0] ifid_rt,
    input  logic             id_br_mispredict,
    output logic             pc_write_en,
    output logic             ifid_write_en,
    output logic             idex_ctrl_zero,
    output logic             ifid_flush
);
    localparam int NUM_SRC = 2;

    logic [NUM_SRC-1:0][REG_W-1:0] srcs;
    logic                          lu_match;

    assign srcs[0] = ifid_rs;
    assign srcs[1] = ifid_rt;

    hz_loaduse_detect #(
        .REG_W   (REG_W),
        .NUM_SRC (NUM_SRC)
    ) u_detect (
        .ld_valid (idex_mem_read),
        .ld_dest  (idex_rt),
        .src_regs (srcs),
        .match    (lu_match)
    );

    hz_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .lu_match  (lu_match),
        .br_mis    (id_br_mispredict),
        .pc_we     (pc_write_en),
        .ifid_we   (ifid_write_en),
        .ctrl_zero (idex_ctrl_zero),
        .flush     (ifid_flush)
    );
endmodule

// File: rtl/hz_stall_flush_chk.sv
module hz_stall_flush_chk #(
    parameter int REG_W = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             idex_mem_read,
    input logic [REG_W-1:0] idex_rt,
    input logic [REG_W-1:0] ifid_rs,
    input logic [REG_W-1:0] ifid_rt,
    input logic             id_br_mispredict,
    input logic             pc_write_en,
    input logic             ifid_write_en,
    input logic             idex_ctrl_zero,
    input logic             ifid_flush
);
    logic raw_match;
    logic was_stall;
    logic was_flush;

    assign raw_match = idex_mem_read && (idex_rt != '0) &&
                       ((idex_rt == ifid_rs) || (idex_rt == ifid_rt));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            was_stall <= 1'b0;
            was_flush <= 1'b0;
        end else begin
            was_stall <= idex_ctrl_zero;
            was_flush <= ifid_flush;
        end
    end

    assert_stall_on_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (raw_match && !was_stall) |-> (!pc_write_en && idex_ctrl_zero));

    assert_no_stall_without_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !idex_mem_read |-> (pc_write_en && !idex_ctrl_zero));

    assert_zero_dest_no_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_rt == '0) |-> !idex_ctrl_zero);

    assert_single_cycle_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        idex_ctrl_zero |=> (!idex_ctrl_zero && pc_write_en));

    assert_flush_on_mispredict_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (id_br_mispredict && !was_flush && !(raw_match && !was_stall)) |-> ifid_flush);

    assert_single_cycle_flush_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ifid_flush |=> !ifid_flush);

    assert_stall_beats_flush_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (idex_ctrl_zero && id_br_mispredict) |=> (id_br_mispredict |-> ifid_flush));

    assert_enables_agree_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (pc_write_en == ifid_write_en) && (idex_ctrl_zero == !pc_write_en)
        && !(ifid_flush && idex_ctrl_zero));
endmodule

bind hz_stall_flush_ctrl hz_stall_flush_chk #(.REG_W(REG_W)) u_chk (
    .clk              (clk),
    .rst_n            (rst_n),
    .idex_mem_read    (idex_mem_read),
    .idex_rt          (idex_rt),
    .ifid_rs          (ifid_rs),
    .ifid_rt          (ifid_rt),
    .id_br_mispredict (id_br_mispredict),
    .pc_write_en      (pc_write_en),
    .ifid_write_en    (ifid_write_en),
    .idex_ctrl_zero   (idex_ctrl_zero),
    .ifid_flush       (ifid_flush)
);

// File: tb/hz_stall_flush_ctrl_tb.sv
`timescale 1ns/1ps
module hz_stall_flush_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mr = 1'b0;
    logic [4:0] lrt = '0;
    logic [4:0] srs = '0;
    logic [4:0] srt = '0;
    logic       mis = 1'b0;
    logic       pc_we, ifid_we, czero, flush;

    int vectors = 0;
    int fails   = 0;
    int mstate  = 0;   // bench model: 0 run, 1 after stall, 2 after flush
    bit done    = 0;

    always #2.5 clk = ~clk;

    hz_stall_flush_ctrl u_dut (
        .clk(clk), .rst_n(rst_n),
        .idex_mem_read(mr), .idex_rt(lrt), .ifid_rs(srs), .ifid_rt(srt),
        .id_br_mispredict(mis),
        .pc_write_en(pc_we), .ifid_write_en(ifid_we),
        .idex_ctrl_zero(czero), .ifid_flush(flush)
    );

    // expected {pc_we, ifid_we, ctrl_zero, flush} from the requirements
    function automatic logic [3:0] expect_out(int st, logic m, logic [4:0] d,
                                              logic [4:0] a, logic [4:0] b, logic br);
        logic dep;
        dep = m && (d != 0) && (d == a || d == b) && (st != 1);
        if (dep)                return 4'b0010;
        else if (br && st != 2) return 4'b1101;
        else                    return 4'b1100;
    endfunction

    function automatic int next_st(logic [3:0] e);
        if (e[1])      return 1;
        else if (e[0]) return 2;
        else           return 0;
    endfunction

    task automatic apply(input logic m, input logic [4:0] d, input logic [4:0] a,
                         input logic [4:0] b, input logic br, input string tag);
        logic [3:0] exp_v, got;
        @(negedge clk);
        mr = m; lrt = d; srs = a; srt = b; mis = br;
        #1;
        exp_v = expect_out(mstate, m, d, a, b, br);
        got   = {pc_we, ifid_we, czero, flush};
        vectors++;
        if (got !== exp_v) begin
            fails++;
            $display("FAIL %s: outputs {pc,ifid,zero,flush} got %b expected %b", tag, got, exp_v);
        end
        @(posedge clk);
        mstate = next_st(exp_v);
    endtask

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        apply(0, 0, 0, 0, 0, "R1 reset idle");
        apply(1, 5, 5, 9, 0, "R2 stall on rs match");
        apply(1, 5, 5, 9, 0, "R5 match ignored after stall");
        apply(1, 7, 1, 7, 0, "R2 stall on rt match");
        apply(0, 0, 0, 0, 0, "R5 release after stall");
        apply(1, 0, 0, 0, 0, "R4 load to reg0");
        apply(0, 3, 3, 3, 0, "R3 no load");
        apply(1, 3, 4, 6, 0, "R3 no register match");
        apply(0, 0, 0, 0, 1, "R6 mispredict flush");
        apply(0, 0, 0, 0, 1, "R7 mispredict ignored after flush");
        apply(1, 2, 2, 0, 1, "R8 stall beats flush");
        apply(1, 2, 2, 0, 1, "R8 flush on retry");
        apply(1, 4, 4, 4, 0, "R2 stall right after flush");
        apply(0, 0, 0, 0, 1, "R6 flush right after stall");
        apply(0, 0, 0, 0, 0, "R9 idle enables agree");
        for (int i = 0; i < 3000; i++) begin
            logic       m, br;
            logic [4:0] d, a, b;
            logic [3:0] e;
            m  = 1'($urandom_range(0, 1));
            br = ($urandom_range(0, 3) == 0);
            d  = 5'($urandom_range(0, 3));
            a  = 5'($urandom_range(0, 3));
            b  = 5'($urandom_range(0, 3));
            e  = expect_out(mstate, m, d, a, b, br);
            if (e[1])      apply(m, d, a, b, br, "R2 random stall");
            else if (e[0]) apply(m, d, a, b, br, "R6 random flush");
            else           apply(m, d, a, b, br, "R3 random run");
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule